// File: doc/BRIEF.md
# Dual-Port RAM with Per-Port Write Modes

The block is a synchronous memory with two fully independent access ports, A and B. Each port has its own clock, enable, write enable, address, write data and read data. The ports share only the storage array. Every port has its own write width and read width, so one port may store bytes and fetch 16-bit words while the other stores nibbles. All addresses count storage units of `UNIT_W` bits. An access that is N units wide covers the N units that start at the address rounded down to a multiple of N. The unit with the lowest address sits in the least significant bits.

Each port has a write mode, set by a parameter, that decides what its data output shows on a write cycle: the value it already had, the freshly written contents, or the contents just replaced. Read data is first captured in a latch stage. It can then pass through an optional output register with its own clock enable. Each of the two stages has its own synchronous set/reset that loads a parameter value instead of memory data. The array starts up holding a parameter image. The result is undefined if both ports write the same unit in the same cycle, so the environment must keep such writes apart.

The block has no state machine. Each port's behaviour is fixed by the priority order of its two stages, which is listed in the requirements.

Top module: `dpr_dual_ram`

## Requirements
- R1: When `en_x` and `we_x` are both high, a clock edge of port x stores `wdata_x` into `WR_W/UNIT_W` units. These units start at `addr_x` rounded down to a multiple of that count. Unit k of the access takes bits `[k*UNIT_W +: UNIT_W]`.
- R2: When `en_x` is high and `we_x` is low, a clock edge loads the port's latch stage with the `RD_W`-bit word at `addr_x` rounded down to a multiple of `RD_W/UNIT_W`. The lowest unit goes in the LSBs. A port without the output register shows the word on `rdata_x` right after that edge.
- R3: Data written through one port can be read through the other port at that port's own read width.
- R4: In old-data mode (`WM_OLD`), a write cycle loads the latch with the read-width word as it was before the write.
- R5: In new-data mode (`WM_NEW`), a write cycle loads the latch with the read-width word after the write has been applied.
- R6: In hold mode (`WM_HOLD`), a write cycle leaves the latch unchanged. The memory is still written.
- R7: With the output register enabled, read data reaches `rdata_x` one edge after the latch. The register loads the latch only on edges where `ce_reg_x` is high, and otherwise keeps its value.
- R8: `rst_reg_x` high at an edge loads the output register with its init value. This happens whatever the level of `ce_reg_x`, and takes priority over capturing the latch.
- R9: `rst_latch_x` high together with `en_x` at an edge loads the latch with its init value instead of memory data. The memory contents are unchanged.
- R10: While `en_x` is low, port x neither writes nor changes its latch, whatever `we_x`, `addr_x`, `wdata_x` and `rst_latch_x` are.
- R11: At start-up the array holds `MEM_INIT`, with unit u at bits `[u*UNIT_W +: UNIT_W]`. Each latch holds its latch init value, and each output register holds its register init value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| en_a | input | 1 | Port A enable |
| we_a | input | 1 | Port A write enable |
| addr_a | input | $clog2(UNITS) | Port A unit address |
| wdata_a | input | A_WR_W | Port A write data |
| rst_latch_a | input | 1 | Port A latch-stage synchronous set/reset |
| rst_reg_a | input | 1 | Port A register-stage synchronous set/reset |
| ce_reg_a | input | 1 | Port A output register clock enable |
| rdata_a | output | A_RD_W | Port A read data |
| clk_b | input | 1 | Port B clock |
| en_b | input | 1 | Port B enable |
| we_b | input | 1 | Port B write enable |
| addr_b | input | $clog2(UNITS) | Port B unit address |
| wdata_b | input | B_WR_W | Port B write data |
| rst_latch_b | input | 1 | Port B latch-stage synchronous set/reset |
| rst_reg_b | input | 1 | Port B register-stage synchronous set/reset |
| ce_reg_b | input | 1 | Port B output register clock enable |
| rdata_b | output | B_RD_W | Port B read data |

## Verification
The main function is tried with a sequence that mixes byte writes and 16-bit reads on a registered old-data port with nibble writes and byte reads on a latch-only new-data port. Alternating the ports tells cross-port sharing and width conversion apart from plain same-port readback. Odd and top-of-array addresses separate correct alignment by rounding down from an off-by-one in the sub-word position. Reads of untouched locations separate the start-up image from stale data. A second instance in hold mode shows that the output keeps its value while the array still takes the write.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
    // What a port's latch stage shows on a write cycle.
    typedef enum logic [1:0] {
        WM_HOLD = 2'd0,
        WM_NEW  = 2'd1,
        WM_OLD  = 2'd2
    } wmode_e;
endpackage

// File: rtl/dpr_store.sv
// Shared array: one bank per writer plus a tag pair per unit that records
// which bank holds the most recent value, so each bank has a single writer.
module dpr_store #(
    parameter int UNIT_W = 4,
    parameter int UNITS  = 64,
    parameter int A_WR_W = 8,
    parameter int A_RD_W = 16,
    parameter int B_WR_W = 4,
    parameter int B_RD_W = 8,
    parameter logic [UNITS*UNIT_W-1:0] MEM_INIT = '0,
    localparam int AW = $clog2(UNITS)
) (
    input  logic              clk_a,
    input  logic              wr_a,
    input  logic [AW-1:0]     addr_a,
    input  logic [A_WR_W-1:0] wdata_a,
    output logic [A_RD_W-1:0] cur_a,
    output logic [A_RD_W-1:0] upd_a,
    input  logic              clk_b,
    input  logic              wr_b,
    input  logic [AW-1:0]     addr_b,
    input  logic [B_WR_W-1:0] wdata_b,
    output logic [B_RD_W-1:0] cur_b,
    output logic [B_RD_W-1:0] upd_b
);
    localparam int A_WRN = A_WR_W / UNIT_W;
    localparam int A_RDN = A_RD_W / UNIT_W;
    localparam int B_WRN = B_WR_W / UNIT_W;
    localparam int B_RDN = B_RD_W / UNIT_W;

    logic [UNIT_W-1:0]        bank_a [UNITS];
    logic [UNIT_W-1:0]        bank_b [UNITS];
    logic [UNITS-1:0]         tag_a;
    logic [UNITS-1:0]         tag_b;
    logic [UNITS*UNIT_W-1:0]  live;
    logic [AW-1:0]            wbase_a, rbase_a, wbase_b, rbase_b;

    initial begin
        tag_a = '0;
        tag_b = '0;
        for (int u = 0; u < UNITS; u++) begin
            bank_a[u] = '0;
            bank_b[u] = MEM_INIT[u*UNIT_W +: UNIT_W];
        end
    end

    // Tags differ: bank A holds the newest value of that unit.
    always_comb begin
        for (int u = 0; u < UNITS; u++)
            live[u*UNIT_W +: UNIT_W] = (tag_a[u] ^ tag_b[u]) ? bank_a[u] : bank_b[u];
    end

    assign wbase_a = addr_a & ~AW'(A_WRN - 1);
    assign rbase_a = addr_a & ~AW'(A_RDN - 1);
    assign wbase_b = addr_b & ~AW'(B_WRN - 1);
    assign rbase_b = addr_b & ~AW'(B_RDN - 1);

    assign cur_a = live[rbase_a*UNIT_W +: A_RD_W];
    assign cur_b = live[rbase_b*UNIT_W +: B_RD_W];

    // Read-width word with this port's pending write merged in.
    always_comb begin
        logic [AW-1:0] u;
        logic [AW-1:0] off;
        for (int i = 0; i < A_RDN; i++) begin
            u   = rbase_a + AW'(i);
            off = u - wbase_a;
            upd_a[i*UNIT_W +: UNIT_W] = live[u*UNIT_W +: UNIT_W];
            if (off < AW'(A_WRN))
                upd_a[i*UNIT_W +: UNIT_W] = wdata_a[off*UNIT_W +: UNIT_W];
        end
    end

    always_comb begin
        logic [AW-1:0] u;
        logic [AW-1:0] off;
        for (int i = 0; i < B_RDN; i++) begin
            u   = rbase_b + AW'(i);
            off = u - wbase_b;
            upd_b[i*UNIT_W +: UNIT_W] = live[u*UNIT_W +: UNIT_W];
            if (off < AW'(B_WRN))
                upd_b[i*UNIT_W +: UNIT_W] = wdata_b[off*UNIT_W +: UNIT_W];
        end
    end

    always @(posedge clk_a) begin
        if (wr_a) begin
            for (int i = 0; i < A_WRN; i++) begin
                bank_a[wbase_a + AW'(i)] <= wdata_a[i*UNIT_W +: UNIT_W];
                tag_a[wbase_a + AW'(i)]  <= ~tag_b[wbase_a + AW'(i)];
            end
        end
    end

    always @(posedge clk_b) begin
        if (wr_b) begin
            for (int i = 0; i < B_WRN; i++) begin
                bank_b[wbase_b + AW'(i)] <= wdata_b[i*UNIT_W +: UNIT_W];
                tag_b[wbase_b + AW'(i)]  <= tag_a[wbase_b + AW'(i)];
            end
        end
    end
endmodule

// File: rtl/dpr_outpath.sv
// Per-port output path: latch stage, then an optional register stage.
module dpr_outpath
    import dpr_pkg::*;
#(
    parameter int          W          = 16,
    parameter wmode_e      MODE       = WM_OLD,
    parameter bit          OUT_REG    = 1'b1,
    parameter logic [W-1:0] INIT_LATCH = '0,
    parameter logic [W-1:0] INIT_REG   = '0
) (
    input  logic         clk,
    input  logic         en,
    input  logic         we,
    input  logic         rst_latch,
    input  logic         rst_reg,
    input  logic         ce_reg,
    input  logic [W-1:0] cur_word,
    input  logic [W-1:0] upd_word,
    output logic [W-1:0] lat_q,
    output logic [W-1:0] dout
);
    logic [W-1:0] lat_r = INIT_LATCH;

    always_ff @(posedge clk) begin
        if (en) begin
            if (rst_latch)
                lat_r <= INIT_LATCH;
            else if (!we)
                lat_r <= cur_word;
            else begin
                unique case (MODE)
                    WM_HOLD: lat_r <= lat_r;
                    WM_NEW:  lat_r <= upd_word;
                    WM_OLD:  lat_r <= cur_word;
                    default: lat_r <= lat_r;
                endcase
            end
        end
    end

    assign lat_q = lat_r;

    generate
        if (OUT_REG) begin : g_reg
            logic [W-1:0] reg_r = INIT_REG;
            always_ff @(posedge clk) begin
                if (rst_reg)
                    reg_r <= INIT_REG;
                else if (ce_reg)
                    reg_r <= lat_r;
            end
            assign dout = reg_r;
        end else begin : g_noreg
            logic unused_reg_ctl;
            assign unused_reg_ctl = rst_reg ^ ce_reg;
            assign dout = lat_r;
        end
    endgenerate
endmodule

// File: rtl/dpr_dual_ram.sv
module dpr_dual_ram
    import dpr_pkg::*;
#(
    parameter int     UNIT_W  = 4,
    parameter int     UNITS   = 64,
    parameter int     A_WR_W  = 8,
    parameter int     A_RD_W  = 16,
    parameter int     B_WR_W  = 4,
    parameter int     B_RD_W  = 8,
    parameter wmode_e A_MODE  = WM_OLD,
    parameter wmode_e B_MODE  = WM_NEW,
    parameter bit     A_OUT_REG = 1'b1,
    parameter bit     B_OUT_REG = 1'b0,
    parameter logic [A_RD_W-1:0] A_INIT_LATCH = '0,
    parameter logic [A_RD_W-1:0] A_INIT_REG   = '0,
    parameter logic [B_RD_W-1:0] B_INIT_LATCH = '0,
    parameter logic [B_RD_W-1:0] B_INIT_REG   = '0,
    parameter logic [UNITS*UNIT_W-1:0] MEM_INIT = '0,
    localparam int AW = $clog2(UNITS)
) (
    input  logic              clk_a,
    input  logic              en_a,
    input  logic              we_a,
    input  logic [AW-1:0]     addr_a,
    input  logic [A_WR_W-1:0] wdata_a,
    input  logic              rst_latch_a,
    input  logic              rst_reg_a,
    input  logic              ce_reg_a,
    output logic [A_RD_W-1:0] rdata_a,
    input  logic              clk_b,
    input  logic              en_b,
    input  logic              we_b,
    input  logic [AW-1:0]     addr_b,
    input  logic [B_WR_W-1:0] wdata_b,
    input  logic              rst_latch_b,
    input  logic              rst_reg_b,
    input  logic              ce_reg_b,
    output logic [B_RD_W-1:0] rdata_b
);
    logic [A_RD_W-1:0] cur_a, upd_a, lat_a;
    logic [B_RD_W-1:0] cur_b, upd_b, lat_b;

    dpr_store #(
        .UNIT_W(UNIT_W), .UNITS(UNITS),
        .A_WR_W(A_WR_W), .A_RD_W(A_RD_W),
        .B_WR_W(B_WR_W), .B_RD_W(B_RD_W),
        .MEM_INIT(MEM_INIT)
    ) u_store (
        .clk_a(clk_a), .wr_a(en_a & we_a), .addr_a(addr_a), .wdata_a(wdata_a),
        .cur_a(cur_a), .upd_a(upd_a),
        .clk_b(clk_b), .wr_b(en_b & we_b), .addr_b(addr_b), .wdata_b(wdata_b),
        .cur_b(cur_b), .upd_b(upd_b)
    );

    dpr_outpath #(
        .W(A_RD_W), .MODE(A_MODE), .OUT_REG(A_OUT_REG),
        .INIT_LATCH(A_INIT_LATCH), .INIT_REG(A_INIT_REG)
    ) u_out_a (
        .clk(clk_a), .en(en_a), .we(we_a), .rst_latch(rst_latch_a),
        .rst_reg(rst_reg_a), .ce_reg(ce_reg_a),
        .cur_word(cur_a), .upd_word(upd_a), .lat_q(lat_a), .dout(rdata_a)
    );

    dpr_outpath #(
        .W(B_RD_W), .MODE(B_MODE), .OUT_REG(B_OUT_REG),
        .INIT_LATCH(B_INIT_LATCH), .INIT_REG(B_INIT_REG)
    ) u_out_b (
        .clk(clk_b), .en(en_b), .we(we_b), .rst_latch(rst_latch_b),
        .rst_reg(rst_reg_b), .ce_reg(ce_reg_b),
        .cur_word(cur_b), .upd_word(upd_b), .lat_q(lat_b), .dout(rdata_b)
    );
endmodule

// File: rtl/dpr_dual_ram_chk.sv
module dpr_dual_ram_chk
    import dpr_pkg::*;
#(
    parameter int     A_RD_W = 16,
    parameter int     B_RD_W = 8,
    parameter wmode_e A_MODE = WM_OLD,
    parameter wmode_e B_MODE = WM_NEW,
    parameter bit     A_OUT_REG = 1'b1,
    parameter bit     B_OUT_REG = 1'b0,
    parameter logic [A_RD_W-1:0] A_INIT_LATCH = '0,
    parameter logic [A_RD_W-1:0] A_INIT_REG   = '0,
    parameter logic [B_RD_W-1:0] B_INIT_LATCH = '0,
    parameter logic [B_RD_W-1:0] B_INIT_REG   = '0
) (
    input logic              clk_a,
    input logic              en_a,
    input logic              we_a,
    input logic              rst_latch_a,
    input logic              rst_reg_a,
    input logic              ce_reg_a,
    input logic [A_RD_W-1:0] lat_a,
    input logic [A_RD_W-1:0] rdata_a,
    input logic              clk_b,
    input logic              en_b,
    input logic              we_b,
    input logic              rst_latch_b,
    input logic              rst_reg_b,
    input logic              ce_reg_b,
    input logic [B_RD_W-1:0] lat_b,
    input logic [B_RD_W-1:0] rdata_b
);
    // R9
    latch_rst_a_chk: assert property (@(posedge clk_a) disable iff (rst_reg_a)
        (en_a && rst_latch_a) |=> (lat_a == A_INIT_LATCH));
    // R9
    latch_rst_b_chk: assert property (@(posedge clk_b) disable iff (rst_reg_b)
        (en_b && rst_latch_b) |=> (lat_b == B_INIT_LATCH));
    // R10
    idle_a_chk: assert property (@(posedge clk_a) disable iff (rst_reg_a)
        !en_a |=> $stable(lat_a));
    // R10
    idle_b_chk: assert property (@(posedge clk_b) disable iff (rst_reg_b)
        !en_b |=> $stable(lat_b));

    generate
        if (A_OUT_REG) begin : g_reg_a
            // R8
            reg_rst_a_chk: assert property (@(posedge clk_a) disable iff (rst_latch_a)
                rst_reg_a |=> (rdata_a == A_INIT_REG));
            // R7
            reg_hold_a_chk: assert property (@(posedge clk_a) disable iff (rst_reg_a)
                !ce_reg_a |=> $stable(rdata_a));
        end
        if (B_OUT_REG) begin : g_reg_b
            // R8
            reg_rst_b_chk: assert property (@(posedge clk_b) disable iff (rst_latch_b)
                rst_reg_b |=> (rdata_b == B_INIT_REG));
            // R7
            reg_hold_b_chk: assert property (@(posedge clk_b) disable iff (rst_reg_b)
                !ce_reg_b |=> $stable(rdata_b));
        end
        if (A_MODE == WM_HOLD) begin : g_hold_a
            // R6
            hold_mode_a_chk: assert property (@(posedge clk_a) disable iff (rst_latch_a)
                (en_a && we_a) |=> $stable(lat_a));
        end
        if (B_MODE == WM_HOLD) begin : g_hold_b
            // R6
            hold_mode_b_chk: assert property (@(posedge clk_b) disable iff (rst_latch_b)
                (en_b && we_b) |=> $stable(lat_b));
        end
    endgenerate
endmodule

bind dpr_dual_ram dpr_dual_ram_chk #(
    .A_RD_W(A_RD_W), .B_RD_W(B_RD_W),
    .A_MODE(A_MODE), .B_MODE(B_MODE),
    .A_OUT_REG(A_OUT_REG), .B_OUT_REG(B_OUT_REG),
    .A_INIT_LATCH(A_INIT_LATCH), .A_INIT_REG(A_INIT_REG),
    .B_INIT_LATCH(B_INIT_LATCH), .B_INIT_REG(B_INIT_REG)
) u_chk (.*);

// File: tb/dpr_dual_ram_tb.sv
module dpr_dual_ram_tb;
    import dpr_pkg::*;

    localparam logic [255:0] INIT_IMG = {16{16'h3C96}};

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        en_a = 0, we_a = 0, rl_a = 0, rr_a = 0, ce_a = 1;
    logic [5:0]  addr_a = '0;
    logic [7:0]  wd_a = '0;
    logic [15:0] rd_a;
    logic        en_b = 0, we_b = 0, rl_b = 0, rr_b = 0, ce_b = 1;
    logic [5:0]  addr_b = '0;
    logic [3:0]  wd_b = '0;
    logic [7:0]  rd_b;
    logic        en_h = 0, we_h = 0;
    logic [5:0]  addr_h = '0;
    logic [7:0]  wd_h = '0;
    logic [15:0] rd_h;
    logic [7:0]  rdb_h;

    dpr_dual_ram #(
        .UNIT_W(4), .UNITS(64), .A_WR_W(8), .A_RD_W(16), .B_WR_W(4), .B_RD_W(8),
        .A_MODE(WM_OLD), .B_MODE(WM_NEW), .A_OUT_REG(1'b1), .B_OUT_REG(1'b0),
        .A_INIT_LATCH(16'h1234), .A_INIT_REG(16'hBEEF),
        .B_INIT_LATCH(8'h5A), .B_INIT_REG(8'hC3), .MEM_INIT(INIT_IMG)
    ) u_dut (
        .clk_a(clk), .en_a(en_a), .we_a(we_a), .addr_a(addr_a), .wdata_a(wd_a),
        .rst_latch_a(rl_a), .rst_reg_a(rr_a), .ce_reg_a(ce_a), .rdata_a(rd_a),
        .clk_b(clk), .en_b(en_b), .we_b(we_b), .addr_b(addr_b), .wdata_b(wd_b),
        .rst_latch_b(rl_b), .rst_reg_b(rr_b), .ce_reg_b(ce_b), .rdata_b(rd_b)
    );

    dpr_dual_ram #(
        .UNIT_W(4), .UNITS(64), .A_WR_W(8), .A_RD_W(16), .B_WR_W(4), .B_RD_W(8),
        .A_MODE(WM_HOLD), .B_MODE(WM_HOLD), .A_OUT_REG(1'b0), .B_OUT_REG(1'b0),
        .A_INIT_LATCH(16'h0000), .A_INIT_REG(16'h0000),
        .B_INIT_LATCH(8'h00), .B_INIT_REG(8'h00), .MEM_INIT(INIT_IMG)
    ) u_hold (
        .clk_a(clk), .en_a(en_h), .we_a(we_h), .addr_a(addr_h), .wdata_a(wd_h),
        .rst_latch_a(1'b0), .rst_reg_a(1'b0), .ce_reg_a(1'b1), .rdata_a(rd_h),
        .clk_b(clk), .en_b(1'b0), .we_b(1'b0), .addr_b(6'd0), .wdata_b(4'h0),
        .rst_latch_b(1'b0), .rst_reg_b(1'b0), .ce_reg_b(1'b1), .rdata_b(rdb_h)
    );

    int  nchk = 0;
    int  nerr = 0;
    bit  done = 0;
    logic [3:0] mdl [64];

    // Vector: [15] port (0=A,1=B), [14] write, [13:8] unit address, [7:0] data.
    localparam logic [15:0] VEC [14] = '{
        16'h4421, 16'h0400, 16'hC50E, 16'h0400, 16'h8400, 16'hFF07, 16'hBE00,
        16'h7EF0, 16'h3C00, 16'h8300, 16'h0000, 16'hC001, 16'h4199, 16'h8100
    };

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] word(int a, int n);
        logic [15:0] r = '0;
        int b = a & ~(n - 1);
        for (int i = 0; i < n; i++) r[i*4 +: 4] = mdl[b + i];
        return r;
    endfunction

    task automatic tick;
        @(posedge clk);
        #2;
    endtask

    // Port A: latch at first edge, output register at the second.
    task automatic op_a(logic we, int a, logic [7:0] d);
        en_a = 1; we_a = we; addr_a = 6'(a); wd_a = d;
        tick();
        en_a = 0; we_a = 0;
        tick();
    endtask

    task automatic op_b(logic we, int a, logic [3:0] d);
        en_b = 1; we_b = we; addr_b = 6'(a); wd_b = d;
        tick();
        en_b = 0; we_b = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [15:0] exp, prev;
        for (int u = 0; u < 64; u++) mdl[u] = INIT_IMG[u*4 +: 4];
        #1;
        // R11: start-up state of both output paths
        chk("R11 reg init A", rd_a, 16'hBEEF);
        chk("R11 latch init B", {8'h00, rd_b}, 16'h005A);
        tick();

        // R1 R2 R3 R4 R5 R11: mixed-port, mixed-width table
        for (int k = 0; k < 14; k++) begin
            logic [15:0] v = VEC[k];
            int a = int'(v[13:8]);
            if (!v[15]) begin
                exp = word(a, 4);
                if (v[14]) begin
                    mdl[(a & ~1)]     = v[3:0];
                    mdl[(a & ~1) + 1] = v[7:4];
                end
                op_a(v[14], a, v[7:0]);
                chk(v[14] ? "R1 R4 write A" : "R2 R3 R11 read A", rd_a, exp);
            end else begin
                if (v[14]) mdl[a] = v[3:0];
                exp = word(a, 2);
                op_b(v[14], a, v[3:0]);
                chk(v[14] ? "R1 R5 write B" : "R2 R3 R11 read B", {8'h00, rd_b}, exp);
            end
        end

        // R7: register adds one edge of latency
        prev = rd_a;
        en_a = 1; addr_a = 6'd8;
        tick();
        chk("R7 latency first edge", rd_a, prev);
        en_a = 0;
        tick();
        chk("R7 latency second edge", rd_a, word(8, 4));

        // R7: register holds while its enable is low
        prev = rd_a;
        ce_a = 0;
        op_a(1'b0, 60, 8'h00);
        chk("R7 ce low hold", rd_a, prev);
        ce_a = 1;
        tick();
        chk("R7 ce high capture", rd_a, word(60, 4));

        // R8: register reset with ce low, priority over capture
        ce_a = 0; rr_a = 1;
        tick();
        chk("R8 reg reset", rd_a, 16'hBEEF);
        rr_a = 0; ce_a = 1;
        tick();
        chk("R8 after reset", rd_a, word(60, 4));

        // R9: latch reset on both ports, memory untouched
        en_a = 1; rl_a = 1; addr_a = 6'd8;
        tick();
        en_a = 0; rl_a = 0;
        tick();
        chk("R9 latch reset A", rd_a, 16'h1234);
        en_b = 1; rl_b = 1; addr_b = 6'd4;
        tick();
        chk("R9 latch reset B", {8'h00, rd_b}, 16'h005A);
        en_b = 0; rl_b = 0;
        op_b(1'b0, 4, 4'h0);
        chk("R9 memory kept", {8'h00, rd_b}, word(4, 2));

        // R10: disabled port ignores write, address and latch reset
        prev = {8'h00, rd_b};
        en_b = 0; we_b = 1; rl_b = 1; addr_b = 6'd10; wd_b = 4'hF;
        tick();
        chk("R10 idle B output", {8'h00, rd_b}, prev);
        we_b = 0; rl_b = 0;
        prev = rd_a;
        en_a = 0; we_a = 1; addr_a = 6'd20; wd_a = 8'h55;
        tick(); tick();
        chk("R10 idle A output", rd_a, prev);
        we_a = 0;
        op_b(1'b0, 10, 4'h0);
        chk("R10 no write B", {8'h00, rd_b}, word(10, 2));
        op_a(1'b0, 20, 8'h00);
        chk("R10 no write A", rd_a, word(20, 4));

        // R6: hold-mode instance keeps its output and still stores the data
        en_h = 1; we_h = 0; addr_h = 6'd8;
        tick();
        chk("R6 hold pre-read", rd_h, 16'h3C96);
        we_h = 1; wd_h = 8'hA7;
        tick();
        chk("R6 hold during write", rd_h, 16'h3C96);
        we_h = 0;
        tick();
        chk("R6 data stored", rd_h, 16'h3CA7);
        en_h = 0;
        chk("R6 other port idle", {8'h00, rdb_h}, 16'h0000);

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule